// File: doc/BRIEF.md
# Undefined-Opcode Substitution Unit

This unit sits on the data path between memory and an 8-bit processor that leaves 46 of its 256 opcode values undefined. A co-executing sequencer gives 44 of those values meaning as new instructions. On every opcode-fetch cycle the unit decodes the fetched byte. It passes ordinary opcodes straight through. For an extension opcode it hands the processor a substitute byte, chosen so that the processor still produces the bus cycles the extended instruction needs. The substitute is the byte itself, another undefined opcode, a legal instruction, or a NOP.

The unit also tells the sequencer what is running. One cycle after the fetch of an extension opcode, it pulses a valid strobe with a 6-bit internal code. Three of the extension opcodes are one-byte bank prefixes. For these the unit records only which bank pointer was named. The selection becomes visible on `far_sel` for the duration of the instruction that follows the prefix. The byte path is combinational within the bus cycle, so the processor reads the substitute in the same cycle. All state advances once per bus cycle, in lock-step with the processor.

Top module: `opcode_subst_unit`

## Requirements
- R1: When `opfetch` is low, `cpu_data` equals `mem_data` whatever its value. `ext_valid` is low in the following cycle, and `far_sel` does not change.
- R2: A fetched opcode outside the extension set passes through unchanged and gives no strobe. This includes the undefined values 0xCB and 0xDB, which are kept in reserve.
- R3: The following extension opcodes reach the processor unchanged: every opcode with low nibble 3 except the prefixes, and 0x02, 0x22, 0x42, 0x62, 0x82, 0xC2 and 0xE2.
- R4: The dedicated far load and store opcodes are replaced as follows: 0x0B→0xAD, 0x1B→0xB1, 0x2B→0xB9, 0x3B→0x8D, 0x4B→0x91, 0x5B→0x99.
- R5: The far transfer opcodes are replaced as follows: 0x5C→0x4C, 0xDC→0x20, 0xFC→0x60.
- R6: The opcodes 0x6B through 0xBB, 0xEB and 0xFB (low nibble 0xB) are replaced by the undefined opcode 0x02.
- R7: The opcodes 0x44, 0x54, 0xD4 and 0xF4 are replaced by the NOP 0xEA.
- R8: In the cycle after a non-prefix extension fetch, `ext_valid` is high and `ext_code` holds that opcode's code. The code is assigned by low nibble: for low nibble 3 it is the high nibble; for low nibble B it is 16 plus the high nibble; for low nibble 2 it is 32 plus half the high nibble; for 0x44, 0x54, 0xD4 and 0xF4 it is 40 to 43; for 0x5C, 0xDC and 0xFC it is 44 to 46. At all other times `ext_valid` is low and `ext_code` is 0.
- R9: The prefix opcodes 0x03, 0x13 and 0x23 pass through unchanged and give no strobe. They name bank pointers 1, 2 and 3 respectively.
- R10: The next non-prefix opcode fetch after a prefix sets `far_sel` to that prefix's pointer number from the next cycle on. `far_sel` keeps this value until the cycle after the following opcode fetch. If several prefixes come in a row, the last one wins. With no prefix pending, that fetch sets `far_sel` to 0.
- R11: While `rst_n` is low, `ext_valid`, `ext_code` and `far_sel` are 0 and any pending prefix is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opfetch | input | 1 | High during an opcode-fetch bus cycle |
| mem_data | input | 8 | Byte read from memory |
| cpu_data | output | 8 | Byte delivered to the processor |
| ext_valid | output | 1 | Extended instruction decoded on the previous fetch |
| ext_code | output | 6 | Internal code of that instruction |
| far_sel | output | 2 | Bank pointer chosen by a prefix (0 means none) |

## Verification
The bench builds the unit with its package defaults: an 8-bit byte and a 6-bit code. With these values the whole 256-value opcode space can be swept, both as fetches and as operand cycles, so every table entry and every legal pass-through is compared. Directed sequences then cover a single prefix, chained prefixes, a prefix in front of an extension opcode, and a reset with a prefix pending. A long random run mixes fetch and operand cycles against the behavioural model.

// File: rtl/opx_pkg.sv
`timescale 1ns/1ps
package opx_pkg;
    localparam int DATA_W = 8;
    localparam int CODE_W = 6;
    localparam int SEL_W  = 2;

    typedef struct packed {
        logic              ext;
        logic              pfx;
        logic [SEL_W-1:0]  sel;
        logic [DATA_W-1:0] sub;
        logic [CODE_W-1:0] code;
    } opx_dec_t;

    typedef struct packed {
        logic [SEL_W-1:0]  pend;
        logic [SEL_W-1:0]  act;
        logic              vld;
        logic [CODE_W-1:0] code;
    } opx_state_t;
endpackage

// File: rtl/opx_decode.sv
`timescale 1ns/1ps
module opx_decode
    import opx_pkg::*;
(
    input  logic [DATA_W-1:0] op,
    output opx_dec_t          dec
);
    localparam logic [3:0] NIB_PAIR   = 4'h2;
    localparam logic [3:0] NIB_BANK   = 4'h3;
    localparam logic [3:0] NIB_ZNOP   = 4'h4;
    localparam logic [3:0] NIB_FAR    = 4'hB;
    localparam logic [3:0] NIB_JUMP   = 4'hC;

    logic [3:0] hi;
    logic [3:0] lo;

    assign hi = op[7:4];
    assign lo = op[3:0];

    always_comb begin
        dec      = '0;
        dec.sub  = op;
        case (lo)
            NIB_PAIR: begin
                if (!hi[0] && hi != 4'hA) begin
                    dec.ext  = 1'b1;
                    dec.code = CODE_W'(32 + int'(hi[3:1]));
                end
            end
            NIB_BANK: begin
                if (hi <= 4'h2) begin
                    dec.pfx = 1'b1;
                    dec.sel = SEL_W'(hi) + SEL_W'(1);
                end else begin
                    dec.ext  = 1'b1;
                    dec.code = CODE_W'(hi);
                end
            end
            NIB_ZNOP: begin
                case (hi)
                    4'h4: begin dec.ext = 1'b1; dec.code = CODE_W'(40); dec.sub = 8'hEA; end
                    4'h5: begin dec.ext = 1'b1; dec.code = CODE_W'(41); dec.sub = 8'hEA; end
                    4'hD: begin dec.ext = 1'b1; dec.code = CODE_W'(42); dec.sub = 8'hEA; end
                    4'hF: begin dec.ext = 1'b1; dec.code = CODE_W'(43); dec.sub = 8'hEA; end
                    default: ;
                endcase
            end
            NIB_FAR: begin
                if (hi != 4'hC && hi != 4'hD) begin
                    dec.ext  = 1'b1;
                    dec.code = CODE_W'(16 + int'(hi));
                    case (hi)
                        4'h0:    dec.sub = 8'hAD;
                        4'h1:    dec.sub = 8'hB1;
                        4'h2:    dec.sub = 8'hB9;
                        4'h3:    dec.sub = 8'h8D;
                        4'h4:    dec.sub = 8'h91;
                        4'h5:    dec.sub = 8'h99;
                        default: dec.sub = 8'h02;
                    endcase
                end
            end
            NIB_JUMP: begin
                case (hi)
                    4'h5: begin dec.ext = 1'b1; dec.code = CODE_W'(44); dec.sub = 8'h4C; end
                    4'hD: begin dec.ext = 1'b1; dec.code = CODE_W'(45); dec.sub = 8'h20; end
                    4'hF: begin dec.ext = 1'b1; dec.code = CODE_W'(46); dec.sub = 8'h60; end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/opx_track.sv
`timescale 1ns/1ps
module opx_track
    import opx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fetch,
    input  opx_dec_t   dec,
    output opx_state_t st_q
);
    opx_state_t st_d;

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.code = '0;
        if (fetch) begin
            if (dec.pfx) begin
                st_d.pend = dec.sel;
            end else begin
                st_d.act  = st_q.pend;
                st_d.pend = '0;
                st_d.vld  = dec.ext;
                st_d.code = dec.ext ? dec.code : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/opcode_subst_unit.sv
`timescale 1ns/1ps
module opcode_subst_unit
    import opx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              opfetch,
    input  logic [DATA_W-1:0] mem_data,
    output logic [DATA_W-1:0] cpu_data,
    output logic              ext_valid,
    output logic [CODE_W-1:0] ext_code,
    output logic [SEL_W-1:0]  far_sel
);
    opx_dec_t   dec;
    opx_state_t st_q;

    opx_decode i_decode (
        .op  (mem_data),
        .dec (dec)
    );

    opx_track i_track (
        .clk   (clk),
        .rst_n (rst_n),
        .fetch (opfetch),
        .dec   (dec),
        .st_q  (st_q)
    );

    assign cpu_data  = opfetch ? dec.sub : mem_data;
    assign ext_valid = st_q.vld;
    assign ext_code  = st_q.code;
    assign far_sel   = st_q.act;
endmodule

// File: rtl/opx_checker.sv
`timescale 1ns/1ps
module opx_checker
    import opx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              opfetch,
    input logic [DATA_W-1:0] mem_data,
    input logic [DATA_W-1:0] cpu_data,
    input logic              ext_valid,
    input logic [CODE_W-1:0] ext_code,
    input logic [SEL_W-1:0]  far_sel
);
    assert_operand_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !opfetch |-> cpu_data == mem_data);

    assert_operand_no_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !opfetch |=> !ext_valid);

    assert_operand_sel_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !opfetch |=> $stable(far_sel));

    assert_reserved_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (opfetch && (mem_data == 8'hCB || mem_data == 8'hDB)) |=> !ext_valid);

    assert_far_load_abs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (opfetch && mem_data == 8'h0B) |-> cpu_data == 8'hAD);

    assert_far_jump_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (opfetch && mem_data == 8'h5C) |-> cpu_data == 8'h4C);

    assert_code_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_valid |-> ext_code == '0);

    assert_prefix_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (opfetch && (mem_data == 8'h03 || mem_data == 8'h13 || mem_data == 8'h23))
        |=> !ext_valid);

    assert_prefix_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (opfetch && (mem_data == 8'h03 || mem_data == 8'h13 || mem_data == 8'h23))
        |-> cpu_data == mem_data);

    assert_prefix_sel_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (opfetch && (mem_data == 8'h03 || mem_data == 8'h13 || mem_data == 8'h23))
        |=> $stable(far_sel));
endmodule

bind opcode_subst_unit opx_checker i_opx_checker (.*);

// File: tb/test_opcode_subst_unit.sv
`timescale 1ns/1ps
module test_opcode_subst_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       opfetch = 1'b0;
    logic [7:0] mem_data = 8'h00;
    logic [7:0] cpu_data;
    logic       ext_valid;
    logic [5:0] ext_code;
    logic [1:0] far_sel;

    int nchk  = 0;
    int nfail = 0;

    // behavioural reference state
    int  m_pend = 0;
    int  m_act  = 0;
    bit  m_vld  = 0;
    int  m_code = 0;

    always #4 clk = ~clk;

    opcode_subst_unit i_opcode_subst_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .opfetch  (opfetch),
        .mem_data (mem_data),
        .cpu_data (cpu_data),
        .ext_valid(ext_valid),
        .ext_code (ext_code),
        .far_sel  (far_sel)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: got 0x%0h, want 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic void ref_dec(input logic [7:0] b, output bit ext, output bit pfx,
                                    output int sel, output int sub, output int code,
                                    output string tag);
        logic [7:0] dedic_out [6] = '{8'hAD, 8'hB1, 8'hB9, 8'h8D, 8'h91, 8'h99};
        logic [7:0] znop_in   [4] = '{8'h44, 8'h54, 8'hD4, 8'hF4};
        logic [7:0] jump_in   [3] = '{8'h5C, 8'hDC, 8'hFC};
        logic [7:0] jump_out  [3] = '{8'h4C, 8'h20, 8'h60};
        int hi = int'(b) / 16;
        int lo = int'(b) % 16;
        ext = 0; pfx = 0; sel = 0; sub = int'(b); code = 0; tag = "R2";
        if (b == 8'h03 || b == 8'h13 || b == 8'h23) begin
            pfx = 1; sel = hi + 1; tag = "R9";
        end else if (lo == 3) begin
            ext = 1; code = hi; tag = "R3";
        end else if (lo == 2 && hi % 2 == 0 && b != 8'hA2) begin
            ext = 1; code = 32 + hi / 2; tag = "R3";
        end else if (lo == 11 && b != 8'hCB && b != 8'hDB) begin
            ext = 1; code = 16 + hi;
            if (hi < 6) begin sub = int'(dedic_out[hi]); tag = "R4"; end
            else        begin sub = 2; tag = "R6"; end
        end
        for (int i = 0; i < 4; i++)
            if (b == znop_in[i]) begin ext = 1; code = 40 + i; sub = 'hEA; tag = "R7"; end
        for (int i = 0; i < 3; i++)
            if (b == jump_in[i]) begin ext = 1; code = 44 + i; sub = int'(jump_out[i]); tag = "R5"; end
    endfunction

    task automatic tick(input bit of, input logic [7:0] d);
        bit ext, pfx; int sel, sub, code; string tag;
        ref_dec(d, ext, pfx, sel, sub, code, tag);
        opfetch  = of;
        mem_data = d;
        #1;
        if (of) check(tag, "cpu_data", int'(cpu_data), sub);
        else    check("R1", "cpu_data operand", int'(cpu_data), int'(d));
        @(posedge clk);
        m_vld = 0; m_code = 0;
        if (of) begin
            if (pfx) m_pend = sel;
            else begin
                m_act = m_pend; m_pend = 0;
                m_vld = ext; m_code = ext ? code : 0;
            end
        end
        @(negedge clk);
        check(of ? "R8" : "R1", "ext_valid", int'(ext_valid), int'(m_vld));
        check("R8", "ext_code", int'(ext_code), m_code);
        check(of ? "R10" : "R1", "far_sel", int'(far_sel), m_act);
    endtask

    initial begin
        #(8 * 150000);
        nfail++;
        $display("FAIL watchdog: run did not finish, got timeout, want completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11", "ext_valid in reset", int'(ext_valid), 0);
        check("R11", "ext_code in reset", int'(ext_code), 0);
        check("R11", "far_sel in reset", int'(far_sel), 0);
        rst_n = 1'b1;

        // full opcode sweep, each fetch followed by an operand cycle
        for (int op = 0; op < 256; op++) begin
            tick(1'b1, 8'(op));
            tick(1'b0, 8'(op) ^ 8'h5A);
        end
        // extension bytes seen as operands must pass (R1)
        for (int op = 0; op < 256; op++) tick(1'b0, 8'(op));

        // single prefix then a legal instruction with operands (R10)
        tick(1'b1, 8'h13);
        tick(1'b1, 8'h8D);
        tick(1'b0, 8'h00);
        tick(1'b0, 8'h34);
        tick(1'b1, 8'hEA);
        tick(1'b1, 8'hEA);
        // chained prefixes, last one wins (R10)
        tick(1'b1, 8'h03);
        tick(1'b1, 8'h23);
        tick(1'b1, 8'hAD);
        tick(1'b0, 8'h10);
        tick(1'b0, 8'h20);
        tick(1'b1, 8'h60);
        // prefix before an extension opcode (R8, R10)
        tick(1'b1, 8'h03);
        tick(1'b1, 8'h0B);
        tick(1'b0, 8'h55);
        tick(1'b1, 8'hFC);

        // reset with a prefix pending (R11)
        tick(1'b1, 8'h23);
        rst_n = 1'b0;
        m_pend = 0; m_act = 0; m_vld = 0; m_code = 0;
        #1;
        check("R11", "far_sel after mid-run reset", int'(far_sel), 0);
        check("R11", "ext_valid after mid-run reset", int'(ext_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        tick(1'b1, 8'hAD);
        tick(1'b1, 8'hEA);

        // random mix
        for (int i = 0; i < 3000; i++)
            tick(($urandom % 3) != 0, 8'($urandom));

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule